// File: doc/BRIEF.md
# Two-Page Opcode Length Predecoder

This block watches the instruction byte stream of an 8-bit accumulator processor, one byte per accepted cycle, and marks where each instruction begins and ends. It does not execute anything. It tells a fetch or trace unit how many bytes belong to the current instruction, which opcode map the opcode came from, and the addressing class of the opcode.

Two prefix bytes switch the next opcode to an alternate map. The length follows from three things: the prefix, the opcode's class and fixed operand count, and, for indexed forms, a decode of the postbyte that can ask for zero, one or two more offset bytes. An opcode that does not exist in an alternate map raises a one-cycle flag. The decoder then treats the following byte as a fresh opcode.

Top module: `opcode_len_predecoder`

## Requirements
- R1: On map 1, byte 0x10 selects map 2 and byte 0x11 selects map 3. The selection applies only to the next opcode, and decoding then returns to map 1. The page_o encoding is 1, 2 and 3 for the three maps.
- R2: len_o is the total number of bytes in the instruction, counting any prefix byte, the opcode and all operand bytes. Its range is 1 to 5.
- R3: For opcodes 0x80-0xFF the high nibble sets the class, except 0x8D. Nibble 8 or C is immediate (class_o 1). Nibble 9 or D is direct with one more byte (class_o 2). Nibble A or E is indexed (class_o 3). Nibble B or F is extended with two more bytes (class_o 4).
- R4: On map 1, the immediate opcodes 0x83, 0x8C, 0x8E, 0xC3, 0xCC and 0xCE take a two-byte operand and every other immediate opcode takes one byte. Every immediate opcode on maps 2 and 3 takes two bytes.
- R5: The relative class (class_o 5) covers three groups. Map 1 opcodes 0x20-0x2F and 0x8D take a one-byte offset. Map 1 opcodes 0x16 and 0x17 take a two-byte offset. Map 2 opcodes 0x21-0x2F take a two-byte offset.
- R6: Map 1 opcodes 0x1A, 0x1C, 0x1E, 0x1F, 0x34-0x37 and 0x3C carry exactly one postbyte (class_o 6).
- R7: An indexed form is the opcode followed by a postbyte. If postbyte bit 7 is set, a low nibble of 1000 or 1100 adds one more byte, and a low nibble of 1001, 1101 or 1111 adds two more bytes. Any other postbyte adds nothing.
- R8: On map 1, the opcodes below 0x80 decode as follows. 0x00-0x0F are direct. 0x30-0x33 and 0x60-0x6F are indexed. 0x70-0x7F are extended. 0x40-0x5F and the remaining 0x1x and 0x3x opcodes are inherent (class_o 0, length 1).
- R9: Map 3 accepts only 0x3F and the opcodes with high nibble 8-B and low nibble 3 or C. Map 2 accepts 0x21-0x2F and 0x3F; low nibble 3 or C with high nibble 8-B; low nibble E with high nibble 8-F; and low nibble F with high nibble 9, A, B, D, E or F. Any other opcode on map 2 or 3 pulses illegal_o for one cycle with no done_o. Decoding then resumes on map 1 with the next byte as an opcode.
- R10: start_o pulses in the cycle after the first byte of an instruction (its prefix or, with no prefix, its opcode) is accepted. done_o pulses in the cycle after the last byte is accepted, and len_o, page_o and class_o are valid with it.
- R11: A byte is taken only when valid_i is high. Cycles with valid_i low change no state and produce no strobe.
- R12: While rst_ni is low, all strobes are low and the decoder waits for a map-1 opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Stream byte |
| valid_i | input | 1 | byte_i is accepted this cycle |
| start_o | output | 1 | First byte of an instruction was taken |
| done_o | output | 1 | Last byte of an instruction was taken |
| len_o | output | 3 | Total instruction length in bytes |
| page_o | output | 2 | Opcode map of the completed instruction (1..3) |
| class_o | output | 3 | Addressing class of the completed instruction |
| illegal_o | output | 1 | Opcode undefined on its map |

## Verification
A bad remaining-byte count or a stale map selection shows up at the ports within a single instruction. done_o arrives a byte early or late, so the following opcode is taken as an operand, and every later start_o, len_o and class_o stays offset until an inherent opcode happens to land on a true boundary. A prefix flag that fails to clear shows a wrong page_o on the very next instruction, or a false illegal_o on a valid map-1 opcode. Each scenario therefore ends with a short map-1 instruction whose outputs show whether the decoder has resynchronised.

// File: rtl/opl_pkg.sv
package opl_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 3;
  localparam int CNT_W  = 2;

  typedef enum logic [2:0] {
    CLS_INH  = 3'd0,
    CLS_IMM  = 3'd1,
    CLS_DIR  = 3'd2,
    CLS_IDX  = 3'd3,
    CLS_EXT  = 3'd4,
    CLS_REL  = 3'd5,
    CLS_POST = 3'd6
  } cls_e;

  typedef enum logic [1:0] {
    ST_OP   = 2'd0,
    ST_POST = 2'd1,
    ST_OPND = 2'd2
  } st_e;

  localparam logic [1:0] MAP1 = 2'd1;
  localparam logic [1:0] MAP2 = 2'd2;
  localparam logic [1:0] MAP3 = 2'd3;
endpackage

// File: rtl/opl_op_dec.sv
module opl_op_dec
  import opl_pkg::*;
(
  input  logic [1:0]        map_i,
  input  logic [BYTE_W-1:0] op_i,
  output logic              ill_o,
  output cls_e              cls_o,
  output logic [CNT_W-1:0]  nops_o
);
  logic [3:0] hi, lo;
  assign hi = op_i[7:4];
  assign lo = op_i[3:0];

  cls_e hcls;
  logic [CNT_W-1:0] hnops;

  // upper half of every map: class by high nibble
  always_comb begin
    unique case (hi[1:0])
      2'd0:    begin hcls = CLS_IMM; hnops = 2'd1; end
      2'd1:    begin hcls = CLS_DIR; hnops = 2'd1; end
      2'd2:    begin hcls = CLS_IDX; hnops = 2'd0; end
      default: begin hcls = CLS_EXT; hnops = 2'd2; end
    endcase
  end

  always_comb begin
    ill_o  = 1'b0;
    cls_o  = CLS_INH;
    nops_o = '0;
    if (map_i == MAP1) begin
      if (hi[3]) begin
        cls_o  = hcls;
        nops_o = hnops;
        if (op_i == 8'h8D) begin
          cls_o = CLS_REL; nops_o = 2'd1;
        end else if (hcls == CLS_IMM &&
                     (lo == 4'h3 || lo == 4'hC || lo == 4'hE) &&
                     !(hi == 4'h8 && lo == 4'hE) || op_i == 8'h8E) begin
          nops_o = 2'd2;
        end
      end else begin
        unique case (hi[2:0])
          3'd0: begin cls_o = CLS_DIR; nops_o = 2'd1; end
          3'd1: begin
            if (op_i == 8'h16 || op_i == 8'h17) begin
              cls_o = CLS_REL; nops_o = 2'd2;
            end else if (op_i == 8'h1A || op_i == 8'h1C || op_i == 8'h1E || op_i == 8'h1F) begin
              cls_o = CLS_POST; nops_o = 2'd1;
            end
          end
          3'd2: begin cls_o = CLS_REL; nops_o = 2'd1; end
          3'd3: begin
            if (lo < 4'h4) cls_o = CLS_IDX;
            else if (lo < 4'h8 || lo == 4'hC) begin
              cls_o = CLS_POST; nops_o = 2'd1;
            end
          end
          3'd6: cls_o = CLS_IDX;
          3'd7: begin cls_o = CLS_EXT; nops_o = 2'd2; end
          default: ;
        endcase
      end
    end else begin
      cls_o  = hcls;
      nops_o = (hcls == CLS_IMM) ? 2'd2 : hnops;
      if (op_i == 8'h3F) begin
        cls_o = CLS_INH; nops_o = '0;
      end else if (map_i == MAP2 && hi == 4'h2 && lo != 4'h0) begin
        cls_o = CLS_REL; nops_o = 2'd2;
      end else if (!hi[3]) begin
        ill_o = 1'b1;
      end else if (map_i == MAP3) begin
        ill_o = !(hi[2] == 1'b0 && (lo == 4'h3 || lo == 4'hC));
      end else begin
        unique case (lo)
          4'h3, 4'hC: ill_o = hi[2];
          4'hE:       ill_o = 1'b0;
          4'hF:       ill_o = (hi[1:0] == 2'd0);
          default:    ill_o = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/opl_post_dec.sv
module opl_post_dec
  import opl_pkg::*;
(
  input  logic [BYTE_W-1:0] pb_i,
  output logic [CNT_W-1:0]  extra_o
);
  always_comb begin
    extra_o = '0;
    if (pb_i[7]) begin
      unique case (pb_i[3:0])
        4'h8, 4'hC:       extra_o = 2'd1;
        4'h9, 4'hD, 4'hF: extra_o = 2'd2;
        default:          extra_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/opcode_len_predecoder.sv
module opcode_len_predecoder
  import opl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              valid_i,
  output logic              start_o,
  output logic              done_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [1:0]        page_o,
  output logic [2:0]        class_o,
  output logic              illegal_o
);
  st_e              st_q, st_n;
  logic [1:0]       map_q, map_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic [LEN_W-1:0] acc_q, acc_n;
  cls_e             cls_q, cls_n;
  logic             start_d, done_d, ill_d;

  logic             dec_ill;
  cls_e             dec_cls;
  logic [CNT_W-1:0] dec_nops;
  logic [CNT_W-1:0] idx_extra;

  opl_op_dec i_op_dec (
    .map_i  (map_q),
    .op_i   (byte_i),
    .ill_o  (dec_ill),
    .cls_o  (dec_cls),
    .nops_o (dec_nops)
  );

  opl_post_dec i_post_dec (
    .pb_i    (byte_i),
    .extra_o (idx_extra)
  );

  always_comb begin
    st_n = st_q; map_n = map_q; rem_n = rem_q; acc_n = acc_q; cls_n = cls_q;
    start_d = 1'b0; done_d = 1'b0; ill_d = 1'b0;
    if (valid_i) begin
      unique case (st_q)
        ST_OP: begin
          start_d = (map_q == MAP1);
          if (map_q == MAP1 && (byte_i == 8'h10 || byte_i == 8'h11)) begin
            map_n = byte_i[0] ? MAP3 : MAP2;
          end else if (dec_ill) begin
            ill_d = 1'b1;
            map_n = MAP1;
          end else begin
            acc_n = (map_q == MAP1) ? LEN_W'(1) : LEN_W'(2);
            cls_n = dec_cls;
            if (dec_cls == CLS_IDX) begin
              st_n = ST_POST;
            end else if (dec_nops == '0) begin
              done_d = 1'b1;
            end else begin
              rem_n = dec_nops;
              st_n  = ST_OPND;
            end
          end
        end
        ST_POST: begin
          acc_n = acc_q + LEN_W'(1);
          if (idx_extra == '0) begin
            done_d = 1'b1;
            st_n   = ST_OP;
          end else begin
            rem_n = idx_extra;
            st_n  = ST_OPND;
          end
        end
        default: begin
          acc_n = acc_q + LEN_W'(1);
          rem_n = rem_q - CNT_W'(1);
          if (rem_q == CNT_W'(1)) begin
            done_d = 1'b1;
            st_n   = ST_OP;
          end
        end
      endcase
      if (done_d) map_n = MAP1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_OP; map_q <= MAP1; rem_q <= '0; acc_q <= '0; cls_q <= CLS_INH;
      start_o <= 1'b0; done_o <= 1'b0; illegal_o <= 1'b0;
      len_o <= '0; page_o <= MAP1; class_o <= '0;
    end else begin
      st_q <= st_n; map_q <= map_n; rem_q <= rem_n; acc_q <= acc_n; cls_q <= cls_n;
      start_o   <= start_d;
      done_o    <= done_d;
      illegal_o <= ill_d;
      if (done_d) begin
        len_o   <= acc_n;
        page_o  <= map_q;
        class_o <= cls_n;
      end
    end
  end
endmodule

// File: rtl/opcode_len_predecoder_chk.sv
module opcode_len_predecoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       start_o,
  input logic       done_o,
  input logic [2:0] len_o,
  input logic [1:0] page_o,
  input logic [2:0] class_o,
  input logic       illegal_o
);
  assert_len_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (len_o >= 3'd1 && len_o <= 3'd5));

  assert_prefix_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && page_o != 2'd1) |-> len_o >= 3'd2);

  assert_page_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> page_o != 2'd0);

  assert_idx_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && class_o == 3'd3) |-> len_o >= ((page_o == 2'd1) ? 3'd2 : 3'd3));

  assert_no_dual_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && illegal_o));

  assert_ill_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o);

  assert_strobe_src_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || done_o || illegal_o) |-> $past(valid_i));
endmodule

bind opcode_len_predecoder opcode_len_predecoder_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .start_o   (start_o),
  .done_o    (done_o),
  .len_o     (len_o),
  .page_o    (page_o),
  .class_o   (class_o),
  .illegal_o (illegal_o)
);

// File: tb/test_opcode_len_predecoder.sv
`timescale 1ns/1ps
module test_opcode_len_predecoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       valid_i = 1'b0;
  logic       start_o, done_o, illegal_o;
  logic [2:0] len_o, class_o;
  logic [1:0] page_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  opcode_len_predecoder i_opcode_len_predecoder (
    .clk_i, .rst_ni, .byte_i, .valid_i,
    .start_o, .done_o, .len_o, .page_o, .class_o, .illegal_o
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b, logic v = 1'b1);
    @(negedge clk_i);
    byte_i  = b;
    valid_i = v;
    @(posedge clk_i);
    #1;
  endtask

  // check a completed instruction on the current sample
  task automatic fin(string tag, int len, int page, int cls);
    chk({tag, " done"}, done_o, 1);
    chk({tag, " len"}, len_o, len);
    chk({tag, " page"}, page_o, page);
    chk({tag, " class"}, class_o, cls);
    chk({tag, " illegal"}, illegal_o, 0);
  endtask

  task automatic mid(string tag);
    chk({tag, " no done"}, done_o, 0);
  endtask

  task automatic t_reset;
    chk("R12 start", start_o, 0);
    chk("R12 done", done_o, 0);
    chk("R12 illegal", illegal_o, 0);
    put(8'h12);
    chk("R10 start", start_o, 1);
    fin("R8 inh", 1, 1, 0);
    put(8'h4F); fin("R8 inh2", 1, 1, 0);
  endtask

  task automatic t_imm;
    put(8'h86); chk("R10 start imm", start_o, 1); mid("R4 imm8");
    put(8'h55); chk("R10 start only first", start_o, 0); fin("R4 imm8", 2, 1, 1);
    put(8'hCC); put(8'h12); mid("R4 imm16"); put(8'h34); fin("R4 LD16", 3, 1, 1);
    put(8'h8E); put(8'h00); put(8'h01); fin("R4 8E", 3, 1, 1);
    put(8'h83); put(8'h00); put(8'h01); fin("R4 83", 3, 1, 1);
    put(8'hC6); put(8'h01); fin("R4 C6", 2, 1, 1);
  endtask

  task automatic t_dir_ext;
    put(8'h96); put(8'h10); fin("R3 dir", 2, 1, 2);
    put(8'hB6); put(8'h10); put(8'h11); fin("R3 ext", 3, 1, 4);
    put(8'h0A); put(8'h10); fin("R8 dir low", 2, 1, 2);
    put(8'h7C); put(8'h10); put(8'h11); fin("R8 ext low", 3, 1, 4);
  endtask

  task automatic t_idx;
    put(8'hA6); put(8'h84); fin("R7 no extra", 2, 1, 3);
    put(8'hA6); put(8'h88); mid("R7 one"); put(8'h01); fin("R7 one", 3, 1, 3);
    put(8'hE6); put(8'h8C); put(8'h01); fin("R7 pcr8", 3, 1, 3);
    put(8'hA6); put(8'h89); put(8'h01); mid("R7 two"); put(8'h02); fin("R7 two", 4, 1, 3);
    put(8'h6E); put(8'h9F); put(8'h01); put(8'h02); fin("R7 ind", 4, 1, 3);
    put(8'hA6); put(8'h08); fin("R7 bit7 clear", 2, 1, 3);
    put(8'h30); put(8'h8D); put(8'h01); put(8'h02); fin("R8 lea", 4, 1, 3);
  endtask

  task automatic t_map2;
    put(8'h10); chk("R10 start prefix", start_o, 1); mid("R1 prefix");
    put(8'h8E); chk("R10 no restart", start_o, 0); put(8'h12); put(8'h34);
    fin("R1 R2 map2 imm", 4, 2, 1);
    put(8'h86); put(8'h01); fin("R1 back to map1", 2, 1, 1);
    put(8'h10); put(8'hAE); put(8'h89); put(8'hAA); put(8'hBB);
    fin("R2 max len", 5, 2, 3);
    put(8'h10); put(8'hDF); put(8'h20); fin("R9 map2 st", 3, 2, 2);
    put(8'h10); put(8'h3F); fin("R9 map2 swi", 2, 2, 0);
  endtask

  task automatic t_map3;
    put(8'h11); put(8'h83); put(8'h00); put(8'h01); fin("R1 map3 imm", 4, 3, 1);
    put(8'h11); put(8'hBC); put(8'h00); put(8'h01); fin("R9 map3 ext", 4, 3, 4);
    put(8'h11); put(8'h3F); fin("R9 map3 swi", 2, 3, 0);
    put(8'h11); put(8'h86);
    chk("R9 map3 illegal", illegal_o, 1);
    chk("R9 illegal no done", done_o, 0);
    put(8'h12);
    chk("R9 pulse ends", illegal_o, 0);
    chk("R9 resync start", start_o, 1);
    fin("R9 resync", 1, 1, 0);
    put(8'h11); put(8'h8E); chk("R9 map3 8E", illegal_o, 1);
  endtask

  task automatic t_map2_ill;
    put(8'h10); put(8'h10); chk("R9 double prefix", illegal_o, 1);
    put(8'h10); put(8'h86); chk("R9 map2 imm8", illegal_o, 1);
    put(8'h10); put(8'h20); chk("R9 map2 20", illegal_o, 1);
    put(8'h10); put(8'hDE); chk("R9 map2 DE ok", illegal_o, 0); put(8'h01);
    fin("R9 map2 DE", 3, 2, 2);
  endtask

  task automatic t_rel;
    put(8'h20); put(8'h05); fin("R5 short", 2, 1, 5);
    put(8'h8D); put(8'hF0); fin("R5 8D", 2, 1, 5);
    put(8'h17); put(8'h01); put(8'h02); fin("R5 long map1", 3, 1, 5);
    put(8'h10); put(8'h27); put(8'h01); put(8'h02); fin("R5 long map2", 4, 2, 5);
  endtask

  task automatic t_post;
    put(8'h1F); put(8'h89); fin("R6 xfer", 2, 1, 6);
    put(8'h34); put(8'hFF); fin("R6 push", 2, 1, 6);
    put(8'h3C); put(8'hEF); fin("R6 wait", 2, 1, 6);
    put(8'h1A); put(8'h50); fin("R6 or cc", 2, 1, 6);
    put(8'h3D); fin("R8 3D inh", 1, 1, 0);
  endtask

  task automatic t_valid;
    put(8'h86);
    put(8'hB6, 1'b0);
    chk("R11 idle no done", done_o, 0);
    chk("R11 idle no start", start_o, 0);
    put(8'h10, 1'b0);
    chk("R11 idle2 no done", done_o, 0);
    put(8'h22); fin("R11 held", 2, 1, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset_pre();
    @(negedge clk_i) rst_ni = 1'b1;
    #1;
    t_reset();
    t_imm();
    t_dir_ext();
    t_idx();
    t_map2();
    t_map3();
    t_map2_ill();
    t_rel();
    t_post();
    t_valid();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic t_reset_pre;
    chk("R12 in reset done", done_o, 0);
    chk("R12 in reset start", start_o, 0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule